// File: doc/BRIEF.md
# Write Strobe and Data Launcher

This block is the controller-side transmitter for memory write data. It accepts a write request together with a burst length and a write latency. After the latency has elapsed it drives the data strobe through three phases. The first is a one-clock low preamble. The second is a toggling burst phase, with one rising and one falling edge per clock. The last is a half-clock low postamble, after which the strobe returns to its high idle level. Edges are modelled as half-cycle phases: each clock carries a level for its first half and a level for its second half.

Write data comes from a show-ahead FIFO. Each entry holds two beats: the beat launched on the rising edge and the beat launched on the falling edge, each with its own mask bits. The block pops one entry per burst clock. If the FIFO is empty during a burst clock, the block still sends the beat, but with every mask bit set so that nothing is written, and it raises an underflow flag.

Requests are kept in a schedule of future burst clocks. Writes that follow each other closely therefore join into one unbroken strobe and data stream.

Top module: `wr_strobe_launcher`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows strb_oe=0, strb_lvl=2'b11, beat_vld=0, fifo_pop=0, underflow=0, dq_mask all ones and dq_data zero, whatever the other inputs do.
- R2: If wr_req is high in cycle T with effective latency L, the first burst cycle is cycle T+L.
- R3: The cycle before the first cycle of a burst is a preamble: strb_oe=1 and strb_lvl=2'b00 (low in both halves).
- R4: A burst cycle shows strb_oe=1, strb_lvl=2'b01 (bit 0 is the first half and is high, bit 1 is the second half and is low), and beat_vld=2'b11. A burst lasts 2 cycles when wr_bl8=0 (4 beats) and 4 cycles when wr_bl8=1 (8 beats).
- R5: After the last burst cycle, if no burst follows within two cycles, one postamble cycle follows with strb_oe=1 and strb_lvl=2'b10 (low, then high). The strobe then idles.
- R6: A request whose first burst cycle directly follows the previous burst's last cycle continues the burst: no preamble or postamble appears between them.
- R7: If exactly one idle cycle separates two bursts, that cycle is a preamble (strb_lvl=2'b00) and not a postamble.
- R8: In a burst cycle with fifo_vld=1, fifo_pop=1, dq_data=fifo_data and dq_mask=fifo_mask. The lower half of each bus is the rising-edge beat and the upper half is the falling-edge beat.
- R9: In a burst cycle with fifo_vld=0, underflow=1, fifo_pop=0, beat_vld=2'b11, dq_mask is all ones and dq_data is zero.
- R10: Outside burst cycles, fifo_pop=0, beat_vld=0, underflow=0, dq_mask is all ones and dq_data is zero, even when fifo_vld=1.
- R11: The effective latency is wr_lat clamped to the range 2 to MAX_LAT. A value below 2 acts as 2 and a value above MAX_LAT acts as MAX_LAT.
- R12: When strb_oe=0, strb_lvl=2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write command, one cycle per write |
| wr_bl8 | input | 1 | 1: eight-beat burst, 0: four-beat burst |
| wr_lat | input | LAT_W | Programmed write latency in clocks |
| fifo_vld | input | 1 | Write FIFO has an entry |
| fifo_data | input | 2*DW | FIFO entry data, rising beat in the low half |
| fifo_mask | input | 2*MW | FIFO entry mask bits, rising beat in the low half |
| fifo_pop | output | 1 | Consume the FIFO entry this cycle |
| strb_oe | output | 1 | Strobe driver enable |
| strb_lvl | output | 2 | Strobe level per half cycle, bit 0 first half |
| beat_vld | output | 2 | Data driven per half cycle |
| dq_data | output | 2*DW | Launched data for both beats |
| dq_mask | output | 2*MW | Launched mask bits, high means do not write |
| underflow | output | 1 | FIFO was empty in a burst cycle |

## Verification
The in-RTL assertions check the order of strobe phases on every cycle. A preamble is always followed by a burst, a burst never drops straight to idle, a postamble never leads into a burst, and an idle strobe can only stay idle or fall into a preamble. The same assertions also check that a pop only occurs on a valid entry during a burst, and that an underflow beat is fully masked. Latency counting, clamping, burst length, the merging of close writes and the pairing of data with strobe edges can only be shown by the bench scenarios. These scenarios compare full cycle-by-cycle traces against an independent schedule model.

// File: rtl/wrl_pkg.sv
// Package: shared strobe phase type and half-cycle level codes.
// Assumes bit 0 of a level code is the first half of the clock.
package wrl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_BURST = 2'd2,
        PH_POST  = 2'd3
    } strb_ph_e;

    localparam logic [1:0] LVL_IDLE  = 2'b11;
    localparam logic [1:0] LVL_PRE   = 2'b00;
    localparam logic [1:0] LVL_BURST = 2'b01;
    localparam logic [1:0] LVL_POST  = 2'b10;

    localparam int BURST_MAX_CYC = 4;
endpackage

// File: rtl/wrl_sched.sv
// Module: burst schedule. Bit k of the schedule marks clock now+k as a
// burst clock. A request writes its burst clocks at the clamped latency.
// Assumes the latency is at least 2 so the preamble fits after the command.
module wrl_sched #(
    parameter int MAX_LAT = 16,
    parameter int LAT_W   = 5,
    parameter int DEPTH   = MAX_LAT + wrl_pkg::BURST_MAX_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             wr_bl8,
    input  logic [LAT_W-1:0] wr_lat,
    output logic             slot_now,
    output logic             slot_next
);
    localparam int MIN_LAT = 2;

    logic [DEPTH-1:0] busy_q;
    logic [DEPTH-1:0] ins;
    int               lat_eff;
    int               ncyc;

    // Clamp the programmed latency and pick the burst length in clocks.
    always_comb begin
        lat_eff = int'(wr_lat);
        if (lat_eff < MIN_LAT) lat_eff = MIN_LAT;
        if (lat_eff > MAX_LAT) lat_eff = MAX_LAT;
        ncyc = wr_bl8 ? 4 : 2;
    end

    // Build the insert mask: positions lat_eff-1 .. lat_eff+ncyc-2.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ins[i] = wr_req && (i >= lat_eff - 1) && (i < lat_eff - 1 + ncyc);
        end
    end

    // Advance the schedule by one clock and merge the new request.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= {1'b0, busy_q[DEPTH-1:1]} | ins;
    end

    assign slot_now  = busy_q[0];
    assign slot_next = busy_q[1];

    // R2
    req_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (busy_q != '0));
endmodule

// File: rtl/wrl_strobe.sv
// Module: strobe phase decoder. It turns the schedule bits into preamble,
// burst, postamble and idle phases, and drives the enable and the levels.
// Assumes the schedule never marks the current clock without the one before.
module wrl_strobe
    import wrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slot_now,
    input  logic        slot_next,
    output strb_ph_e    phase,
    output logic        strb_oe,
    output logic [1:0]  strb_lvl
);
    logic was_burst_q;

    // Remember whether the previous clock was a burst clock.
    always_ff @(posedge clk) begin
        if (!rst_n) was_burst_q <= 1'b0;
        else        was_burst_q <= slot_now;
    end

    // Pick the phase; a preamble takes the place of a postamble.
    always_comb begin
        if (slot_now)         phase = PH_BURST;
        else if (slot_next)   phase = PH_PRE;
        else if (was_burst_q) phase = PH_POST;
        else                  phase = PH_IDLE;
    end

    // Map the phase onto driver enable and half-cycle levels.
    always_comb begin
        unique case (phase)
            PH_PRE:   begin strb_oe = 1'b1; strb_lvl = LVL_PRE;   end
            PH_BURST: begin strb_oe = 1'b1; strb_lvl = LVL_BURST; end
            PH_POST:  begin strb_oe = 1'b1; strb_lvl = LVL_POST;  end
            default:  begin strb_oe = 1'b0; strb_lvl = LVL_IDLE;  end
        endcase
    end

    // R3
    pre_then_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PRE |=> phase == PH_BURST);
    // R5
    burst_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_BURST |=> phase != PH_IDLE);
    // R5
    post_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_POST |=> (phase == PH_IDLE || phase == PH_PRE));
    // R3
    idle_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IDLE |=> (phase == PH_IDLE || phase == PH_PRE));
endmodule

// File: rtl/wrl_beat.sv
// Module: beat path. In a burst clock it passes one FIFO entry (two beats)
// to the pins, or a fully masked empty beat with an underflow flag.
// Assumes a show-ahead FIFO whose entry is visible while fifo_vld is high.
module wrl_beat #(
    parameter int DW = 16,
    parameter int MW = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_burst,
    input  logic            fifo_vld,
    input  logic [2*DW-1:0] fifo_data,
    input  logic [2*MW-1:0] fifo_mask,
    output logic            fifo_pop,
    output logic [1:0]      beat_vld,
    output logic [2*DW-1:0] dq_data,
    output logic [2*MW-1:0] dq_mask,
    output logic            underflow
);
    logic take;

    // Decide whether a real entry is launched this clock.
    always_comb begin
        take      = in_burst && fifo_vld;
        fifo_pop  = take;
        underflow = in_burst && !fifo_vld;
        beat_vld  = in_burst ? 2'b11 : 2'b00;
    end

    // Drive data and mask; anything not taken from the FIFO is masked off.
    always_comb begin
        dq_data = take ? fifo_data : '0;
        dq_mask = take ? fifo_mask : '1;
    end

    // R9
    uf_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (beat_vld == 2'b11 && (&dq_mask) && !fifo_pop));
endmodule

// File: rtl/wr_strobe_launcher.sv
// Module: write strobe and data launcher top. It ties the schedule, the
// strobe decoder and the beat path together.
// Assumes wr_lat changes only between writes and that requests respect the
// command spacing, so bursts never overlap.
module wr_strobe_launcher #(
    parameter int MAX_LAT = 16,
    parameter int LAT_W   = 5,
    parameter int DW      = 16,
    parameter int MW      = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic            wr_bl8,
    input  logic [LAT_W-1:0] wr_lat,
    input  logic            fifo_vld,
    input  logic [2*DW-1:0] fifo_data,
    input  logic [2*MW-1:0] fifo_mask,
    output logic            fifo_pop,
    output logic            strb_oe,
    output logic [1:0]      strb_lvl,
    output logic [1:0]      beat_vld,
    output logic [2*DW-1:0] dq_data,
    output logic [2*MW-1:0] dq_mask,
    output logic            underflow
);
    import wrl_pkg::*;

    localparam int DEPTH = MAX_LAT + BURST_MAX_CYC;

    logic     slot_now;
    logic     slot_next;
    strb_ph_e phase;

    wrl_sched #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .DEPTH(DEPTH)) u_sched (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_bl8(wr_bl8),
        .wr_lat(wr_lat), .slot_now(slot_now), .slot_next(slot_next)
    );

    wrl_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .slot_now(slot_now), .slot_next(slot_next),
        .phase(phase), .strb_oe(strb_oe), .strb_lvl(strb_lvl)
    );

    wrl_beat #(.DW(DW), .MW(MW)) u_beat (
        .clk(clk), .rst_n(rst_n), .in_burst(phase == PH_BURST),
        .fifo_vld(fifo_vld), .fifo_data(fifo_data), .fifo_mask(fifo_mask),
        .fifo_pop(fifo_pop), .beat_vld(beat_vld), .dq_data(dq_data),
        .dq_mask(dq_mask), .underflow(underflow)
    );

    // R8
    pop_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_vld && strb_lvl == LVL_BURST && strb_oe));
    // R12
    quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_oe |-> (strb_lvl == LVL_IDLE && beat_vld == 2'b00));
endmodule

// File: tb/wr_strobe_launcher_tb.sv
module wr_strobe_launcher_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int MW = 2;
    localparam int TRACE = 46;
    localparam logic [7:0] NONE = 8'hFF;

    typedef struct packed {
        logic [7:0] tag;
        logic       bl8a;
        logic [4:0] lata;
        logic [7:0] d2;
        logic       bl8b;
        logic [4:0] latb;
        logic [7:0] uf;
    } scen_t;

    localparam scen_t TBL [9] = '{
        '{8'd2,  1'b0, 5'd2,  NONE, 1'b0, 5'd0, NONE},
        '{8'd2,  1'b1, 5'd5,  NONE, 1'b0, 5'd0, NONE},
        '{8'd11, 1'b0, 5'd0,  NONE, 1'b0, 5'd0, NONE},
        '{8'd11, 1'b1, 5'd31, NONE, 1'b0, 5'd0, NONE},
        '{8'd6,  1'b0, 5'd3,  8'd2, 1'b0, 5'd3, NONE},
        '{8'd7,  1'b0, 5'd3,  8'd3, 1'b1, 5'd3, NONE},
        '{8'd9,  1'b1, 5'd4,  NONE, 1'b0, 5'd0, 8'd6},
        '{8'd6,  1'b1, 5'd2,  8'd4, 1'b0, 5'd2, NONE},
        '{8'd6,  1'b0, 5'd6,  8'd1, 1'b0, 5'd7, 8'd8}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_req = 1'b0;
    logic            wr_bl8 = 1'b0;
    logic [4:0]      wr_lat = 5'd2;
    logic            fifo_vld = 1'b0;
    logic [2*DW-1:0] fifo_data;
    logic [2*MW-1:0] fifo_mask;
    logic            fifo_pop, strb_oe, underflow;
    logic [1:0]      strb_lvl, beat_vld;
    logic [2*DW-1:0] dq_data;
    logic [2*MW-1:0] dq_mask;
    logic [7:0]      cnt;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // FIFO model: entry content follows a pop counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= 8'd0;
        else if (fifo_pop) cnt <= cnt + 8'd1;
    end
    assign fifo_data = {cnt ^ 8'hA5, cnt, ~cnt, cnt + 8'd3};
    assign fifo_mask = cnt[3:0];

    wr_strobe_launcher #(.MAX_LAT(16), .LAT_W(5), .DW(DW), .MW(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_bl8(wr_bl8),
        .wr_lat(wr_lat), .fifo_vld(fifo_vld), .fifo_data(fifo_data),
        .fifo_mask(fifo_mask), .fifo_pop(fifo_pop), .strb_oe(strb_oe),
        .strb_lvl(strb_lvl), .beat_vld(beat_vld), .dq_data(dq_data),
        .dq_mask(dq_mask), .underflow(underflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int clamp_lat(input int l);
        if (l < 2)  return 2;
        if (l > 16) return 16;
        return l;
    endfunction

    function automatic string scen_name(input int t);
        case (t)
            2:       return "R2 latency";
            6:       return "R6 back-to-back";
            7:       return "R7 one-cycle gap";
            9:       return "R9 underflow";
            11:      return "R11 latency clamp";
            default: return "scenario";
        endcase
    endfunction

    task automatic run_scen(input scen_t s);
        bit b [0:TRACE+4];
        int la, lb, na, nb;
        string nm;
        nm = scen_name(int'(s.tag));
        for (int i = 0; i <= TRACE + 4; i++) b[i] = 1'b0;
        la = clamp_lat(int'(s.lata));
        na = s.bl8a ? 4 : 2;
        for (int i = 0; i < na; i++) b[la + i] = 1'b1;
        if (s.d2 != NONE) begin
            lb = clamp_lat(int'(s.latb));
            nb = s.bl8b ? 4 : 2;
            for (int i = 0; i < nb; i++) b[int'(s.d2) + lb + i] = 1'b1;
        end
        for (int o = 0; o < TRACE; o++) begin
            logic [2:0]  exp_s;
            logic [39:0] exp_d, act_d;
            string       sreq, dreq;
            bit          vld;
            @(posedge clk);
            #1;
            vld    = !(s.uf != NONE && o == int'(s.uf));
            wr_req = (o == 0) || (s.d2 != NONE && o == int'(s.d2));
            wr_bl8 = (o == 0) ? s.bl8a : s.bl8b;
            wr_lat = (o == 0) ? s.lata : s.latb;
            fifo_vld = vld;
            @(negedge clk);
            if (b[o]) begin
                exp_s = 3'b101; sreq = "R4";
            end else if (b[o + 1]) begin
                exp_s = 3'b100; sreq = "R3";
            end else if (o > 0 && b[o - 1]) begin
                exp_s = 3'b110; sreq = "R5";
            end else begin
                exp_s = 3'b011; sreq = "R12";
            end
            chk({strb_oe, strb_lvl} == exp_s, sreq, $sformatf("%s strobe o=%0d", nm, o),
                64'({strb_oe, strb_lvl}), 64'(exp_s));
            act_d = {beat_vld, fifo_pop, underflow, dq_mask, dq_data};
            if (b[o] && vld) begin
                exp_d = {2'b11, 1'b1, 1'b0, fifo_mask, fifo_data}; dreq = "R8";
            end else if (b[o]) begin
                exp_d = {2'b11, 1'b0, 1'b1, 4'hF, 32'h0}; dreq = "R9";
            end else begin
                exp_d = {2'b00, 1'b0, 1'b0, 4'hF, 32'h0}; dreq = "R10";
            end
            chk(act_d == exp_d, dreq, $sformatf("%s beats o=%0d", nm, o),
                64'(act_d), 64'(exp_d));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds the outputs quiet even with a request and a full FIFO.
        rst_n = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk);
            #1;
            wr_req = 1'b1; wr_bl8 = 1'b1; wr_lat = 5'd2; fifo_vld = 1'b1;
            @(negedge clk);
            chk({strb_oe, strb_lvl, beat_vld, fifo_pop, underflow} == 7'b0110000,
                "R1", "reset strobe/beat", 64'({strb_oe, strb_lvl, beat_vld, fifo_pop, underflow}),
                64'(7'b0110000));
            chk(dq_mask == 4'hF && dq_data == '0, "R1", "reset data/mask",
                64'({dq_mask, dq_data}), 64'({4'hF, 32'h0}));
        end
        @(posedge clk);
        #1;
        wr_req = 1'b0;
        rst_n  = 1'b1;
        // R12: idle after reset, the strobe stays high and undriven.
        @(negedge clk);
        chk({strb_oe, strb_lvl} == 3'b011, "R12", "idle after reset",
            64'({strb_oe, strb_lvl}), 64'(3'b011));
        // Table of scenarios: R2, R6, R7, R9, R11 and the phase checks.
        for (int k = 0; k < 9; k++) run_scen(TBL[k]);
        // Directed corner: latency 1 must behave like latency 2 (R11).
        run_scen('{8'd11, 1'b1, 5'd1, NONE, 1'b0, 5'd0, NONE});
        // Directed corner: underflow on the first beat of a short burst (R9).
        run_scen('{8'd9, 1'b0, 5'd3, NONE, 1'b0, 5'd0, 8'd3});
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule